// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block picks one winner out of fifteen maskable interrupt requests and raises a pending flag whenever a request may be taken. By default the sources follow a fixed order. A 4-bit promotion field in an 8-bit configuration register can lift any one source to the top. Every other source keeps its default relative order. A global mask input and a per-source enable vector gate every request, including a promoted one. The reported winner is always the true source index and never its rank.

The same register holds four mode-dependent configuration bits. Their reset values come from a 2-bit mode strap. Software can write the register only while the global mask is set. The four configuration bits also need the special-mode bit to be set. A separate fixed-order encoder ranks the six non-maskable sources.

Top module: `irq_priority_resolver`

## Requirements
- R1: While reset is held at a clock edge, the promotion field (register bits 3..0) loads binary 0101, whatever the mode strap says.
- R2: While reset is held at a clock edge, register bits 7..4 load a value chosen by the mode strap. Strap 00 loads 0000, strap 01 loads 0011, strap 10 loads 1100 and strap 11 loads 0111. Bit 6 is the special-mode bit.
- R3: `rdData` always shows the whole register. Bits 7..4 are the configuration bits and bits 3..0 are the promotion field.
- R4: A write strobe while `globalMask` is 0 leaves every register bit unchanged.
- R5: A write while `globalMask` is 1 loads bits 3..0 on the next edge. Bits 7..4 load only if register bit 6 was 1 before that edge; otherwise they keep their value.
- R6: With no promotion in effect, the active source with the lowest index wins. The indices in order are: 0 IRQ, 1 real-time, 2..4 input capture 1..3, 5..8 output compare 1..4, 9 capture 4/compare 5, 10 timer overflow, 11 accumulator overflow, 12 accumulator edge, 13 SPI, 14 SCI.
- R7: A promotion value of 0..14 makes that source win whenever it is active. When it is not active, the default order decides. Value 15 leaves the default order in force.
- R8: When `globalMask` is 1, `pending` is 0 and `winner` is 0.
- R9: A source whose enable bit is 0 never wins, even when it is promoted.
- R10: `winner` is the source index of the winning request, not its position in the priority order.
- R11: `nmWinner` is the lowest set index of `nmReq`. The order is 0 reset, 1 clock monitor, 2 watchdog, 3 XIRQ, 4 illegal opcode, 5 software interrupt. `nmValid` is high exactly when any `nmReq` bit is set, and `nmWinner` is 0 when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeStrap | input | 2 | Operating-mode strap that selects the reset values |
| globalMask | input | 1 | Global interrupt mask, 1 = inhibited |
| reqIn | input | 15 | Maskable request lines, registered upstream |
| enIn | input | 15 | Per-source local enables |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register contents |
| winner | output | 4 | Index of the winning maskable source |
| pending | output | 1 | A maskable request is takeable |
| nmReq | input | 6 | Non-maskable request lines |
| nmWinner | output | 3 | Index of the highest-ranked non-maskable request |
| nmValid | output | 1 | Any non-maskable request present |

## Verification
The winner, the pending flag and the non-maskable outputs are combinational, so they are due in the same cycle as the request, enable and mask inputs. The bench drives those inputs on a falling edge and samples after a short settle, before the next rising edge. Register writes and the reset loads appear on `rdData` one rising edge after the strobe or reset, so every register check samples on the falling edge that follows that rising edge. Each vector first programs the promotion field with the mask set, waits that one edge, and only then applies its request pattern.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int unsigned NUM_SRC   = 15;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned CFG_W     = 4;
  localparam int unsigned NUM_NM    = 6;
  localparam int unsigned NM_W      = 3;
  localparam logic [SEL_W-1:0] PSEL_RESET = 4'b0101;
  localparam int unsigned SMOD_POS  = 2;   // position of the special-mode bit inside cfg[3:0]

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } opMode_e;

  typedef struct packed {
    logic loadSel;
    logic loadCfg;
  } regStrobe_t;

  function automatic logic [CFG_W-1:0] cfgResetValue(input opMode_e mode);
    case (mode)
      MODE_SINGLE: cfgResetValue = 4'b0000;
      MODE_EXPAND: cfgResetValue = 4'b0011;
      MODE_BOOT:   cfgResetValue = 4'b1100;
      default:     cfgResetValue = 4'b0111;
    endcase
  endfunction
endpackage

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
  import irqp_pkg::*;
(
  input  logic       wrEn,
  input  logic       globalMask,
  input  logic       specialMode,
  output regStrobe_t strobe
);
  logic writeOpen;

  always_comb begin
    writeOpen      = wrEn & globalMask;
    strobe.loadSel = writeOpen;
    strobe.loadCfg = writeOpen & specialMode;
  end
endmodule

// File: rtl/irqp_nm_encoder.sv
module irqp_nm_encoder #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = W'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqp_datapath.sv
module irqp_datapath
  import irqp_pkg::*;
#(
  parameter int unsigned N     = NUM_SRC,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned CW    = CFG_W,
  parameter logic [SW-1:0] SEL_INIT = PSEL_RESET
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    modeStrap,
  input  logic          globalMask,
  input  logic [N-1:0]  reqIn,
  input  logic [N-1:0]  enIn,
  input  regStrobe_t    strobe,
  input  logic [CW+SW-1:0] wrData,
  output logic [CW+SW-1:0] rdData,
  output logic          specialMode,
  output logic [SW-1:0] winner,
  output logic          pending
);
  logic [CW-1:0] cfgQ;
  logic [SW-1:0] selQ;
  logic [N-1:0]  live;
  logic [N-1:0]  promoteHit;
  logic [SW-1:0] dfltIdx;
  logic          dfltAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= cfgResetValue(opMode_e'(modeStrap));
      selQ <= SEL_INIT;
    end else begin
      if (strobe.loadSel) selQ <= wrData[SW-1:0];
      if (strobe.loadCfg) cfgQ <= wrData[CW+SW-1:SW];
    end
  end

  assign rdData      = {cfgQ, selQ};
  assign specialMode = cfgQ[SMOD_POS];

  // Gated requests and per-source promotion match
  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      assign live[g]       = reqIn[g] & enIn[g] & ~globalMask;
      assign promoteHit[g] = live[g] && (selQ == SW'(g));
    end
  endgenerate

  always_comb begin
    dfltIdx = '0;
    dfltAny = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        dfltIdx = SW'(i);
        dfltAny = 1'b1;
      end
    end
  end

  always_comb begin
    pending = dfltAny;
    winner  = (|promoteHit) ? selQ : dfltIdx;
  end
endmodule

// File: rtl/irq_priority_resolver.sv
module irq_priority_resolver
  import irqp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeStrap,
  input  logic        globalMask,
  input  logic [14:0] reqIn,
  input  logic [14:0] enIn,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic [3:0]  winner,
  output logic        pending,
  input  logic [5:0]  nmReq,
  output logic [2:0]  nmWinner,
  output logic        nmValid
);
  regStrobe_t strobe;
  logic       specialMode;

  irqp_ctrl u_ctrl (
    .wrEn        (wrEn),
    .globalMask  (globalMask),
    .specialMode (specialMode),
    .strobe      (strobe)
  );

  irqp_datapath #(
    .N  (NUM_SRC),
    .SW (SEL_W),
    .CW (CFG_W),
    .SEL_INIT (PSEL_RESET)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .modeStrap   (modeStrap),
    .globalMask  (globalMask),
    .reqIn       (reqIn),
    .enIn        (enIn),
    .strobe      (strobe),
    .wrData      (wrData),
    .rdData      (rdData),
    .specialMode (specialMode),
    .winner      (winner),
    .pending     (pending)
  );

  irqp_nm_encoder #(
    .N (NUM_NM),
    .W (NM_W)
  ) u_nm (
    .req   (nmReq),
    .idx   (nmWinner),
    .valid (nmValid)
  );
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        globalMask,
  input logic [14:0] reqIn,
  input logic [14:0] enIn,
  input logic        wrEn,
  input logic [7:0]  rdData,
  input logic [3:0]  winner,
  input logic        pending,
  input logic [5:0]  nmReq,
  input logic [2:0]  nmWinner,
  input logic        nmValid
);
  logic [14:0] liveReq;
  logic        selLive;
  logic        lowerLive;
  assign liveReq   = reqIn & enIn;
  assign selLive   = (rdData[3:0] != 4'd15) && liveReq[rdData[3:0]];
  assign lowerLive = |(liveReq & ((15'd1 << winner) - 15'd1));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    globalMask |-> (!pending && winner == 4'd0));

  assert_winner_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (reqIn[winner] && enIn[winner]));

  assert_write_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !globalMask) |=> $stable(rdData));

  assert_promoted_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!globalMask && selLive) |-> (pending && winner == rdData[3:0]));

  assert_default_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && winner != rdData[3:0]) |-> !lowerLive);

  assert_nm_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    nmValid |-> (nmReq[nmWinner] && (nmReq & ((6'd1 << nmWinner) - 6'd1)) == 6'd0));

  assert_nm_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    nmValid == (nmReq != 6'd0));
endmodule

bind irq_priority_resolver irqp_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .globalMask (globalMask),
  .reqIn      (reqIn),
  .enIn       (enIn),
  .wrEn       (wrEn),
  .rdData     (rdData),
  .winner     (winner),
  .pending    (pending),
  .nmReq      (nmReq),
  .nmWinner   (nmWinner),
  .nmValid    (nmValid)
);

// File: tb/tb_irq_priority_resolver.sv
`timescale 1ns/1ps
module tb_irq_priority_resolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeStrap = 2'b00;
  logic        globalMask = 1'b1;
  logic [14:0] reqIn = '0;
  logic [14:0] enIn = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  winner;
  logic        pending;
  logic [5:0]  nmReq = '0;
  logic [2:0]  nmWinner;
  logic        nmValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_priority_resolver dut (.*);

  // Row: sel[39:36] mask[35] req[34:20] en[19:5] expWinner[4:1] expPending[0]
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {4'd5,  1'b0, 15'h0000, 15'h7FFF, 4'd0,  1'b0},  // R8 nothing requested
    {4'd15, 1'b0, 15'h7FFF, 15'h7FFF, 4'd0,  1'b1},  // R6 all active
    {4'd15, 1'b0, 15'h6000, 15'h7FFF, 4'd13, 1'b1},  // R6 SPI over SCI
    {4'd14, 1'b0, 15'h4001, 15'h7FFF, 4'd14, 1'b1},  // R7 SCI promoted
    {4'd14, 1'b0, 15'h0001, 15'h7FFF, 4'd0,  1'b1},  // R7 promoted idle
    {4'd7,  1'b0, 15'h0086, 15'h7FFF, 4'd7,  1'b1},  // R7 middle promoted
    {4'd7,  1'b0, 15'h0086, 15'h7F7F, 4'd1,  1'b1},  // R9 promoted disabled
    {4'd3,  1'b1, 15'h7FFF, 15'h7FFF, 4'd0,  1'b0},  // R8 global mask
    {4'd15, 1'b0, 15'h0C00, 15'h0800, 4'd11, 1'b1},  // R9 enable gating
    {4'd0,  1'b0, 15'h0300, 15'h7FFF, 4'd8,  1'b1},  // R10 index
    {4'd9,  1'b0, 15'h0300, 15'h7FFF, 4'd9,  1'b1}   // R10 promoted index
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] mode);
    @(negedge clk);
    modeStrap = mode;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic mask, input logic [7:0] data);
    @(negedge clk);
    globalMask = mask;
    wrEn = 1'b1;
    wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 R2 R3: reset values in every mode
    for (int m = 0; m < 4; m++) begin
      logic [3:0] expCfg;
      case (m)
        0: expCfg = 4'b0000;
        1: expCfg = 4'b0011;
        2: expCfg = 4'b1100;
        default: expCfg = 4'b0111;
      endcase
      doReset(2'(m));
      #1;
      check("R1", rdData[3:0], 4'b0101);
      check("R2", rdData[7:4], expCfg);
      check("R3", rdData, {expCfg, 4'b0101});
    end

    // Vector table, single-chip mode
    doReset(2'b00);
    for (int i = 0; i < NV; i++) begin
      writeReg(1'b1, {4'b0000, VEC[i][39:36]});
      check("R5", rdData[3:0], VEC[i][39:36]);
      @(negedge clk);
      globalMask = VEC[i][35];
      reqIn      = VEC[i][34:20];
      enIn       = VEC[i][19:5];
      #1;
      check("R6/R7/R8/R9/R10 winner", winner, VEC[i][4:1]);
      check("R6/R7/R8/R9/R10 pending", pending, VEC[i][0]);
    end

    // R4: write ignored with mask clear, checked via register and resolution
    reqIn = 15'h0009; enIn = 15'h7FFF;
    writeReg(1'b1, 8'h03);
    writeReg(1'b0, 8'h00);
    check("R4 register", rdData, 8'h03);
    check("R4 winner", winner, 3);

    // R5: upper bits locked outside special mode
    writeReg(1'b1, 8'hF2);
    check("R5 locked", rdData, 8'h02);

    // R5: test mode allows upper bits; clearing the special bit then locks them
    doReset(2'b11);
    writeReg(1'b1, 8'h8A);
    check("R5 special write", rdData, 8'h8A);
    writeReg(1'b1, 8'hFF);
    check("R5 relocked", rdData, 8'h8F);

    // R7: code 15 keeps the default order
    globalMask = 1'b0; reqIn = 15'h4100; enIn = 15'h7FFF;
    #1;
    check("R7 code15", winner, 8);

    // R11: non-maskable order
    nmReq = 6'b000000; #1;
    check("R11 none valid", nmValid, 0);
    check("R11 none idx", nmWinner, 0);
    nmReq = 6'b111000; #1;
    check("R11 xirq", nmWinner, 3);
    check("R11 valid", nmValid, 1);
    nmReq = 6'b100001; #1;
    check("R11 reset first", nmWinner, 0);
    nmReq = 6'b100000; #1;
    check("R11 swi only", nmWinner, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule